// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This block is the add/subtract slice of a 32-bit integer execution pipeline. Each accepted operation carries two register values, a 16-bit immediate, two destination register indices and a 3-bit operation code. The unit works out the sum or difference in two's complement. For the signed operations it also detects overflow. The result goes out through a single registered output stage, together with the destination index and a write-enable for the writeback stage.

Signed and unsigned forms always give the same result bits. They differ only in trapping. When a signed operation overflows, the unit raises `out_ovf` and drops `out_wr_en`, so the destination register is not written.

Both the input side and the output side are valid/ready streams. An operation transfers on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, every output holds still. In that case `in_ready` is low, so a new operation cannot overwrite the held result. The unit sets `in_ready = !out_valid || out_ready`, which lets one operation per cycle flow through when the consumer is ready.

Top module: `iadd_trap_unit`

## Requirements
- R1: Op codes 0 (signed add) and 1 (unsigned add) give out_result = in_rs + in_rt modulo 2^32 and out_dest = in_rd_idx.
- R2: Op codes 2 (signed subtract) and 3 (unsigned subtract) give out_result = in_rs - in_rt modulo 2^32 and out_dest = in_rd_idx.
- R3: Op codes 4 (signed add-immediate) and 5 (unsigned add-immediate) give out_result = in_rs + sign-extended in_imm and out_dest = in_rt_idx.
- R4: For op codes 0, 2 and 4, a result outside the signed 32-bit range sets out_ovf=1 and out_wr_en=0. Otherwise out_ovf=0 and out_wr_en=1.
- R5: Op codes 1, 3, 5, 6 and 7 always give out_ovf=0 and out_wr_en=1.
- R6: A signed op and its unsigned counterpart give identical out_result for the same operands, overflow included.
- R7: An operation accepted at a clock edge appears with out_valid=1 after that edge. in_ready equals !out_valid || out_ready. While out_valid=1 and out_ready=0, out_valid and every output field stay unchanged.
- R8: During and right after reset, out_valid=0.
- R9: Op codes 6 and 7 behave as unsigned add (R1 result and destination).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 3 | Operation code (see R1 to R5, R9) |
| in_rs | input | 32 | First source register value |
| in_rt | input | 32 | Second source register value |
| in_imm | input | 16 | Immediate operand |
| in_rd_idx | input | 5 | Destination index for register forms |
| in_rt_idx | input | 5 | Destination index for immediate forms |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Sum or difference |
| out_dest | output | 5 | Destination register index |
| out_wr_en | output | 1 | Writeback may write out_dest |
| out_ovf | output | 1 | Overflow exception |

## Verification
Directed operands sit on each side of the signed limits. Pairs such as 0x7FFFFFFF+1, 0x80000000-1 and 0x80000000+0x80000000 separate a true overflow from the ordinary carry-out of -1 + -1. Each pair runs under both the signed and the unsigned code, which shows that only trapping differs. Negative immediates and the 0x8000 immediate test the sign extension and the choice of destination index. A pseudo-random stream runs against an irregular out_ready pattern, so results must hold and stay in order under back-pressure.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDU  = 3'd1,
    OP_SUB   = 3'd2,
    OP_SUBU  = 3'd3,
    OP_ADDI  = 3'd4,
    OP_ADDIU = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } iadd_op_e;

  function automatic logic op_traps(iadd_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
  endfunction
endpackage

// File: rtl/iadd_operand_prep.sv
module iadd_operand_prep
  import iadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  iadd_op_e          op,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  output logic [DATA_W-1:0] opnd_b,
  output logic              carry_in,
  output logic [IDX_W-1:0]  dest,
  output logic              trap_en
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    opnd_b   = rt_val;
    carry_in = 1'b0;
    dest     = rd_idx;
    unique case (op)
      OP_SUB, OP_SUBU: begin
        opnd_b   = ~rt_val;
        carry_in = 1'b1;
      end
      OP_ADDI, OP_ADDIU: begin
        opnd_b = imm_ext;
        dest   = rt_idx;
      end
      default: ;
    endcase
  end

  assign trap_en = op_traps(op);
endmodule

// File: rtl/iadd_sum_core.sv
module iadd_sum_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic              trap_en,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic same_sign;
  assign sum       = opnd_a + opnd_b + {{(DATA_W-1){1'b0}}, carry_in};
  assign same_sign = (opnd_a[MSB] == opnd_b[MSB]);
  assign ovf       = trap_en && same_sign && (sum[MSB] != opnd_a[MSB]);

  localparam logic signed [DATA_W:0] MAX_POS = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W:0] MIN_NEG = {2'b11, {(DATA_W-1){1'b0}}};
  logic signed [DATA_W:0] wide_ref;
  logic                   range_out;
  assign wide_ref  = $signed({opnd_a[MSB], opnd_a}) + $signed({opnd_b[MSB], opnd_b})
                   + $signed({{DATA_W{1'b0}}, carry_in});
  assign range_out = (wide_ref > MAX_POS) || (wide_ref < MIN_NEG);

  always_comb begin
    assert_range_match_R4: assert (!trap_en || (ovf == range_out));
    assert_no_overflow_R5: assert (trap_en || !ovf);
  end
endmodule

// File: rtl/iadd_out_stage.sv
module iadd_out_stage #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic [IDX_W-1:0]  d_dest,
  input  logic              d_wr_en,
  input  logic              d_ovf,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_result,
  output logic [IDX_W-1:0]  q_dest,
  output logic              q_wr_en,
  output logic              q_ovf
);
  logic take;
  assign acc_ready = !q_valid || q_ready;
  assign take      = acc_valid && acc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (acc_ready) begin
      q_valid <= acc_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      q_result <= d_result;
      q_dest   <= d_dest;
      q_wr_en  <= d_wr_en;
      q_ovf    <= d_ovf;
    end
  end

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> q_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_result) && $stable(q_dest)
                               && $stable(q_wr_en) && $stable(q_ovf)));
endmodule

// File: rtl/iadd_trap_unit.sv
module iadd_trap_unit
  import iadd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [DATA_W-1:0] in_rt,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [IDX_W-1:0]  in_rd_idx,
  input  logic [IDX_W-1:0]  in_rt_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dest,
  output logic              out_wr_en,
  output logic              out_ovf
);
  iadd_op_e          op;
  logic [DATA_W-1:0] opnd_b, sum;
  logic              carry_in, trap_en, ovf;
  logic [IDX_W-1:0]  dest;

  assign op = iadd_op_e'(in_op);

  iadd_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_prep (
    .op(op), .rt_val(in_rt), .imm(in_imm), .rd_idx(in_rd_idx), .rt_idx(in_rt_idx),
    .opnd_b(opnd_b), .carry_in(carry_in), .dest(dest), .trap_en(trap_en)
  );

  iadd_sum_core #(.DATA_W(DATA_W)) u_core (
    .opnd_a(in_rs), .opnd_b(opnd_b), .carry_in(carry_in), .trap_en(trap_en),
    .sum(sum), .ovf(ovf)
  );

  iadd_out_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(in_valid), .acc_ready(in_ready),
    .d_result(sum), .d_dest(dest), .d_wr_en(!ovf), .d_ovf(ovf),
    .q_valid(out_valid), .q_ready(out_ready),
    .q_result(out_result), .q_dest(out_dest), .q_wr_en(out_wr_en), .q_ovf(out_ovf)
  );

  assert_write_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> !out_wr_en);
  assert_ready_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/tb_iadd_trap_unit.sv
module tb_iadd_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_rs = '0, in_rt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_rd_idx = '0, in_rt_idx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wr_en, out_ovf;

  always #5 clk = ~clk;

  iadd_trap_unit dut (.*);

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dest;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, seen = 0, sent = 0;
  bit finished = 0;
  bit ready_random = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // expected model built from R1..R5, R9
  task automatic send(logic [2:0] op, logic [31:0] rs, logic [31:0] rt,
                      logic [15:0] imm, logic [4:0] rdi, logic [4:0] rti);
    exp_t e;
    longint sa, sb, s;
    bit trap;
    sa = longint'($signed(rs));
    case (op)
      3'd2, 3'd3: begin sb = longint'($signed(rt)); s = sa - sb; e.tag = "R2"; e.dest = rdi; end
      3'd4, 3'd5: begin sb = longint'($signed(imm)); s = sa + sb; e.tag = "R3"; e.dest = rti; end
      3'd6, 3'd7: begin sb = longint'($signed(rt)); s = sa + sb; e.tag = "R9"; e.dest = rdi; end
      default:    begin sb = longint'($signed(rt)); s = sa + sb; e.tag = "R1"; e.dest = rdi; end
    endcase
    trap = (op == 3'd0) || (op == 3'd2) || (op == 3'd4);
    e.res = s[31:0];
    e.ovf = trap && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
    exp_q.push_back(e);
    sent++;
    in_op = op; in_rs = rs; in_rt = rt; in_imm = imm;
    in_rd_idx = rdi; in_rt_idx = rti; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // back-pressure pattern, changed away from sampling points
  int unsigned lfsr_r = 32'h1ACE;
  always @(posedge clk) begin
    #2;
    if (ready_random) begin
      lfsr_r = lfsr_r * 1103515245 + 12345;
      out_ready = lfsr_r[16] | lfsr_r[19];
    end else begin
      out_ready = 1'b1;
    end
  end

  // monitor / scoreboard
  logic        hold_pending = 0;
  logic [31:0] h_res;
  logic [4:0]  h_dest;
  logic        h_wr, h_ovf;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pending) begin
        check(out_valid && out_result == h_res && out_dest == h_dest &&
              out_wr_en == h_wr && out_ovf == h_ovf, "R7", "held output",
              out_result, h_res);
      end
      check(in_ready == (!out_valid || out_ready), "R7", "in_ready rule", in_ready,
            !out_valid || out_ready);
      hold_pending <= out_valid && !out_ready;
      h_res <= out_result; h_dest <= out_dest; h_wr <= out_wr_en; h_ovf <= out_ovf;
      if (out_valid && out_ready) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected result", out_result, 0);
        end else begin
          e = exp_q.pop_front();
          seen++;
          check(out_result == e.res, e.tag, "result", out_result, e.res);
          check(out_dest == e.dest, e.tag, "dest", out_dest, e.dest);
          if (e.ovf)
            check(out_ovf && !out_wr_en, "R4", "trap/wr_en", {out_ovf, out_wr_en}, 2'b10);
          else
            check(!out_ovf && out_wr_en, "R5", "no trap/wr_en", {out_ovf, out_wr_en}, 2'b01);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R7", "watchdog expired", seen, sent);
    report();
  end

  initial begin
    int unsigned seed = 32'h2468ACE1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    // R1 / R4 / R5 / R6: add limits, signed versus unsigned
    send(3'd0, 32'd5, 32'd7, 16'h0, 5'd3, 5'd9);
    send(3'd0, 32'h7FFFFFFF, 32'd1, 16'h0, 5'd4, 5'd9);
    send(3'd1, 32'h7FFFFFFF, 32'd1, 16'h0, 5'd4, 5'd9);
    send(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd5, 5'd9);
    send(3'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd6, 5'd9);
    send(3'd1, 32'h80000000, 32'h80000000, 16'h0, 5'd6, 5'd9);
    // R2: subtract limits
    send(3'd2, 32'd3, 32'd5, 16'h0, 5'd7, 5'd9);
    send(3'd2, 32'h80000000, 32'd1, 16'h0, 5'd8, 5'd9);
    send(3'd3, 32'h80000000, 32'd1, 16'h0, 5'd8, 5'd9);
    send(3'd2, 32'd0, 32'h80000000, 16'h0, 5'd10, 5'd9);
    // R3: immediates and sign extension
    send(3'd4, 32'd100, 32'hDEAD, 16'hFFEC, 5'd1, 5'd11);
    send(3'd4, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd1, 5'd12);
    send(3'd5, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd1, 5'd12);
    send(3'd5, 32'd0, 32'h0, 16'h8000, 5'd1, 5'd13);
    // R9: spare codes
    send(3'd6, 32'h7FFFFFFF, 32'd1, 16'h0, 5'd14, 5'd2);
    send(3'd7, 32'h12345678, 32'h11111111, 16'h0, 5'd15, 5'd2);
    // random stream under back-pressure (R7)
    ready_random = 1;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      seed = seed * 1664525 + 1013904223; a = seed;
      seed = seed * 1664525 + 1013904223; b = seed;
      if (seed[3]) a[31:30] = b[31:30];
      send(seed[27:25], a, b, b[15:0] ^ a[31:16], a[4:0], b[9:5]);
    end
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    ready_random = 0;
    repeat (3) @(negedge clk);
    check(seen == sent, "R7", "all results delivered", seen, sent);
    report();
  end
endmodule